// File: doc/BRIEF.md
# Command-Addressed Serial Register Port

This block is a four-wire serial slave that lets an external host read and write a small bank of registers. The bank itself lives outside the block. The host lowers the chip select and clocks in a one-byte command. The top bit of the command chooses the direction: 1 is a write and 0 is a read. The low five bits choose the register address. Data bytes for that register follow the command, most significant byte first. Each address has a fixed width of one or two bytes, and that width sets how many bytes the transaction carries.

SCLK, DIN and CS are brought into the system clock domain through synchronisers, and their edges are detected there. For this reason the system clock must run at least four times faster than SCLK. Write data goes to the bank one byte at a time through a single-cycle strobe. For a read, the addressed word is captured when the command byte ends and is then shifted out on DOUT. Raising CS at any point abandons the transaction. A byte that was cut short is never written.

Top module: `ser_reg_port`

## Requirements
- R1: After reset, and whenever CS is deasserted (which includes the moment before every CS falling edge), the port waits for a command byte, and dout_en_o is low.
- R2: In the command byte, bit 7 set to 1 means write and set to 0 means read. Bits 4:0 give the address. Bits 6:5 have no effect.
- R3: DIN is sampled on each falling edge of SCLK, most significant bit first. dout_o changes only after a rising edge of SCLK while CS is active, and it sends read data most significant bit first.
- R4: An address whose bit is set in both PRESENT_MASK and WIDE_MASK is two bytes wide. Every other address is one byte wide. For a two-byte register, the high byte is transferred first.
- R5: Each completed write data byte to an implemented address produces exactly one single-cycle wr_en_o pulse carrying wr_addr_o and wr_data_o. wr_hi_o is 1 for the first byte of a two-byte register and 0 otherwise. A narrow register receives its byte in the low half.
- R6: A read returns the value on rd_data_i at the moment the command byte completes. A one-byte register returns only rd_data_i[7:0].
- R7: An address whose bit is clear in PRESENT_MASK reads as zero and ignores writes (no wr_en_o pulse). It still uses a one-byte data phase.
- R8: Deasserting CS mid-transaction aborts it. dout_en_o goes low, and a partly received byte produces no write.
- R9: Once the last data bit of the register has been transferred, the port returns to command mode even while CS stays low, so transactions can run back to back.
- R10: dout_en_o is high only during the data phase of a read while CS is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCLK |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| cs_ni | input | 1 | Active-low chip select |
| dout_o | output | 1 | Serial read data |
| dout_en_o | output | 1 | Output enable for the DOUT pad driver |
| rd_addr_o | output | 5 | Read address to the register bank, valid when the command completes |
| rd_data_i | input | 16 | Read word from the register bank |
| wr_en_o | output | 1 | Single-cycle write strobe |
| wr_addr_o | output | 5 | Write address |
| wr_hi_o | output | 1 | 1 selects the high byte, 0 selects the low byte |
| wr_data_o | output | 8 | Write byte |

## Verification
The bench drives several situations that a faulty design would get wrong:
- **Abort after the first byte of a two-byte write.** The first byte must land in the bank and the partial second byte must not. A design that commits a partial byte would corrupt the low half.
- **Back-to-back transactions under a continuously low CS, including one to an unimplemented address.** A byte count off by one would misread the next command byte as data.
- **Narrow-register reads, where the upper bank bits are non-zero.** Wrong masking would leak those bits onto DOUT.
- **Commands with bits 6:5 set.** An address decoded too wide would miss the target register.
- **Aborts in the middle of a read and in the middle of a command.** These must drop the output enable and leave the next transaction unaffected.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W   = 5;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic din_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic din_o,
  output logic cs_act_o
);
  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] din_q;
  logic [STAGES-1:0] cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '1;
      din_q  <= '0;
      cs_q   <= '1;
    end else begin
      sclk_q <= (STAGES+1)'({sclk_q, sclk_i});
      din_q  <= STAGES'({din_q, din_i});
      cs_q   <= STAGES'({cs_q, cs_ni});
    end
  end

  // din and sclk taps share the same delay so the sample aligns with the edge
  assign sclk_rise_o =  sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign sclk_fall_o = ~sclk_q[STAGES-1] &  sclk_q[STAGES];
  assign din_o       = din_q[STAGES-1];
  assign cs_act_o    = ~cs_q[STAGES-1];
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter logic [NUM_REGS-1:0] PRESENT_MASK = '1,
  parameter logic [NUM_REGS-1:0] WIDE_MASK    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic              rd_phase_o,
  output logic              ld_o,
  output logic [ADDR_W-1:0] ld_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_hi_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  phase_e              phase_q;
  logic [BYTE_W-2:0]   sh_q;
  logic [2:0]          bit_q;
  logic [1:0]          left_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [BYTE_W-1:0]   rx_byte;
  logic                byte_done;
  logic                wr_en_q, wr_hi_q;
  logic [BYTE_W-1:0]   wr_data_q;

  assign rx_byte   = {sh_q, din_i};
  assign byte_done = cs_act_i && fall_i && (bit_q == 3'd7);
  assign ld_o      = byte_done && (phase_q == PH_CMD) && !rx_byte[BYTE_W-1];
  assign ld_addr_o = rx_byte[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      sh_q      <= '0;
      bit_q     <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_hi_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_CMD;
        bit_q   <= '0;
      end else if (fall_i) begin
        sh_q  <= rx_byte[BYTE_W-2:0];
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (phase_q == PH_CMD) begin
            addr_q  <= rx_byte[ADDR_W-1:0];
            left_q  <= (PRESENT_MASK[rx_byte[ADDR_W-1:0]] && WIDE_MASK[rx_byte[ADDR_W-1:0]])
                       ? 2'd2 : 2'd1;
            phase_q <= rx_byte[BYTE_W-1] ? PH_WR : PH_RD;
          end else begin
            if (phase_q == PH_WR && PRESENT_MASK[addr_q]) begin
              wr_en_q   <= 1'b1;
              wr_hi_q   <= (left_q == 2'd2);
              wr_data_q <= rx_byte;
            end
            left_q <= left_q - 2'd1;
            if (left_q == 2'd1) phase_q <= PH_CMD;
          end
        end
      end
    end
  end

  assign rd_phase_o = (phase_q == PH_RD);
  assign wr_en_o    = wr_en_q;
  assign wr_addr_o  = addr_q;
  assign wr_hi_o    = wr_hi_q;
  assign wr_data_o  = wr_data_q;

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q); // R5
  AST_WR_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> PRESENT_MASK[addr_q]); // R7
  AST_LEFT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_CMD) |-> (left_q == 2'd1 || left_q == 2'd2)); // R4
  AST_ABORT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (phase_q == PH_CMD && bit_q == 3'd0)); // R8
endmodule

// File: rtl/srp_tx.sv
module srp_tx
  import srp_pkg::*;
#(
  parameter logic [NUM_REGS-1:0] PRESENT_MASK = '1,
  parameter logic [NUM_REGS-1:0] WIDE_MASK    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              rd_phase_i,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              dout_o,
  output logic              dout_en_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] ld_word;
  logic              dout_q, en_q;

  // narrow registers sit in the top byte so shifting is always MSB first
  always_comb begin
    if (!PRESENT_MASK[ld_addr_i])   ld_word = '0;
    else if (WIDE_MASK[ld_addr_i])  ld_word = rd_data_i;
    else                            ld_word = {rd_data_i[BYTE_W-1:0], {BYTE_W{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= cs_act_i && rd_phase_i;
      if (!cs_act_i) begin
        dout_q <= 1'b0;
      end else if (ld_i) begin
        sh_q <= ld_word;
      end else if (rise_i && rd_phase_i) begin
        dout_q <= sh_q[WORD_W-1];
        sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign dout_o    = dout_q;
  assign dout_en_o = en_q;

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_i && !rise_i) |=> $stable(dout_q)); // R3
  AST_EN_OFF_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !en_q); // R8
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import srp_pkg::*;
#(
  parameter int                  SYNC_STAGES  = 2,
  parameter logic [NUM_REGS-1:0] PRESENT_MASK = 32'h0000_00FF,
  parameter logic [NUM_REGS-1:0] WIDE_MASK    = 32'h0000_00F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              cs_ni,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_hi_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic rise, fall, din_s, cs_act, rd_phase, ld;

  srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .din_i, .cs_ni,
    .sclk_rise_o(rise), .sclk_fall_o(fall), .din_o(din_s), .cs_act_o(cs_act)
  );

  srp_ctrl #(.PRESENT_MASK(PRESENT_MASK), .WIDE_MASK(WIDE_MASK)) u_ctrl (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .fall_i(fall), .din_i(din_s),
    .rd_phase_o(rd_phase), .ld_o(ld), .ld_addr_o(rd_addr_o),
    .wr_en_o, .wr_addr_o, .wr_hi_o, .wr_data_o
  );

  srp_tx #(.PRESENT_MASK(PRESENT_MASK), .WIDE_MASK(WIDE_MASK)) u_tx (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .rise_i(rise), .rd_phase_i(rd_phase),
    .ld_i(ld), .ld_addr_i(rd_addr_o), .rd_data_i, .dout_o, .dout_en_o
  );
endmodule

// File: tb/ser_reg_port_test.sv
module ser_reg_port_test;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, din = 1'b0, cs_n = 1'b1;
  logic dout_o, dout_en_o, wr_en_o, wr_hi_o;
  logic [4:0] rd_addr_o, wr_addr_o;
  logic [15:0] rd_data_i;
  logic [7:0] wr_data_o;
  logic [15:0] bank [32];
  logic [15:0] mbank [32];
  logic [13:0] expq [$];
  int total = 0, bad = 0, cs_hi_cnt = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  ser_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .din_i(din), .cs_ni(cs_n),
    .dout_o, .dout_en_o, .rd_addr_o, .rd_data_i,
    .wr_en_o, .wr_addr_o, .wr_hi_o, .wr_data_o
  );

  assign rd_data_i = bank[rd_addr_o];

  // external register bank: receives the strobes the port produces
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bank[i] <= 16'h0;
      bank[3] <= 16'hA1C3;
      bank[9] <= 16'h1234;
    end else if (wr_en_o) begin
      if (wr_hi_o) bank[wr_addr_o][15:8] <= wr_data_o;
      else         bank[wr_addr_o][7:0]  <= wr_data_o;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the expected write stream and CS state
  always @(negedge clk) begin
    if (rst_n) begin
      cs_hi_cnt = cs_n ? cs_hi_cnt + 1 : 0;
      if (cs_hi_cnt > 4) chk("R10 enable off with CS high", {15'd0, dout_en_o}, 16'd0);
      if (wr_en_o) begin
        if (expq.size() == 0) chk("R5 unexpected write", {2'b0, wr_addr_o, wr_hi_o, wr_data_o}, 16'h3FFF);
        else chk("R5 write strobe", {2'b0, wr_addr_o, wr_hi_o, wr_data_o}, {2'b0, expq.pop_front()});
      end
    end
  end

  function automatic bit m_present(input logic [4:0] a); return a < 5'd8; endfunction
  function automatic bit m_wide(input logic [4:0] a); return a >= 5'd4 && a < 5'd8; endfunction

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) din = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = dout_o;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk) cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [15:0] v);
    logic [7:0] rx;
    logic [4:0] a = cmd[4:0];
    xbits(cmd, 8, rx);
    if (m_wide(a)) begin
      expq.push_back({a, 1'b1, v[15:8]});
      mbank[a][15:8] = v[15:8];
      xbits(v[15:8], 8, rx);
    end
    if (m_present(a)) begin
      expq.push_back({a, 1'b0, v[7:0]});
      mbank[a][7:0] = v[7:0];
    end
    xbits(v[7:0], 8, rx);
    repeat (4) @(negedge clk);
    chk("R5 all writes seen", 16'(expq.size()), 16'd0);
  endtask

  task automatic do_read(input logic [7:0] cmd, input string req);
    logic [7:0] rx, hi;
    logic [4:0] a = cmd[4:0];
    logic [15:0] exp;
    xbits(cmd, 8, rx);
    chk("R10 enable in read data phase", {15'd0, dout_en_o}, 16'd1);
    exp = !m_present(a) ? 16'h0 : m_wide(a) ? mbank[a] : {8'h0, mbank[a][7:0]};
    hi = 8'h0;
    if (m_wide(a)) xbits(8'h00, 8, hi);
    xbits(8'h00, 8, rx);
    chk(req, {hi, rx}, exp);
    repeat (2) @(negedge clk);
    chk("R9 enable off after last bit", {15'd0, dout_en_o}, 16'd0);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 32; i++) mbank[i] = 16'h0;
    mbank[3] = 16'hA1C3;
    mbank[9] = 16'h1234;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset enable low", {15'd0, dout_en_o}, 16'd0);
    chk("R1 reset no write", {15'd0, wr_en_o}, 16'd0);

    cs_low(); do_write(8'h82, 16'h005A); cs_high();          // R5 narrow
    cs_low(); do_read(8'h02, "R6 R3 narrow readback"); cs_high();
    cs_low(); do_write(8'h85, 16'hBEEF); cs_high();          // R4 wide
    cs_low(); do_read(8'h05, "R4 wide readback high first"); cs_high();
    cs_low(); do_read(8'h03, "R6 narrow masks upper byte"); cs_high();
    cs_low(); do_write(8'hE2, 16'h0033); cs_high();          // R2 bits 6:5 ignored
    cs_low(); do_read(8'h62, "R2 read with bits 6:5 set"); cs_high();

    // R7 + R9: unimplemented address, then back-to-back without CS
    cs_low();
    do_write(8'h89, 16'h0077);
    do_read(8'h09, "R7 unimplemented reads zero");
    do_read(8'h02, "R9 back-to-back after one-byte unimplemented");
    cs_high();

    // R8: abort inside the second byte of a wide write
    cs_low();
    xbits(8'h86, 8, rx);
    expq.push_back({5'd6, 1'b1, 8'h12});
    mbank[6][15:8] = 8'h12;
    xbits(8'h12, 8, rx);
    xbits(8'hFF, 4, rx);
    cs_high();
    chk("R8 partial byte not written", 16'(expq.size()), 16'd0);
    cs_low(); do_read(8'h06, "R8 only full byte committed"); cs_high();

    // R8 + R1: abort during read, then a clean read
    cs_low();
    xbits(8'h05, 8, rx);
    xbits(8'h00, 3, rx);
    cs_high();
    chk("R8 enable off after read abort", {15'd0, dout_en_o}, 16'd0);
    cs_low(); do_read(8'h05, "R1 fresh command after CS edge"); cs_high();

    // R1: abort inside command byte
    cs_low(); xbits(8'h80, 4, rx); cs_high();
    cs_low(); do_read(8'h02, "R1 recovery after command abort"); cs_high();

    repeat (10) @(negedge clk);
    report();
  end
endmodule